// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block collects interrupt events from a set of pulse-type sources and holds each one in a sticky flag. It combines the flags with a single level-type external request, masks the result with per-source enable bits and one global enable, and presents the CPU with a request and the index of the most urgent pending source. A flag stays pending while its enable bit or the global enable is off. It is serviced later, in priority order, once it is allowed through.

The request and the vector index form a valid/ready pair: `irq_o` is valid and `take_i` is ready. A vector is taken only in a cycle where both are high. The request may drop, or its index may change, before it is taken, because a higher-priority source can arrive or a level request can go away. The CPU must therefore sample `vec_o` in the same cycle it raises `take_i`. When a vector is taken, the global enable turns off and the flag of the taken pulse source is cleared. A return-from-interrupt strobe turns the global enable back on. Software may also set the global enable inside a handler to allow nesting.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags, all enable bits and the global enable are 0, and `irq_o` is 0.
- R2: A cycle with `evt_i[k]` high sets `flags_o[k]` at the next clock edge, whatever the mask and global enable. The flag then stays set until it is cleared.
- R3: A cycle with `flg_wr_i` high clears, at the next edge, every flag whose bit in `flg_wdata_i` is 1. Flags whose bit is 0 are unchanged.
- R4: `irq_o` is 1 exactly when the global enable is set and at least one enabled source is pending. Vector 0 is the level source, gated by mask bit 0. Vector k+1 is pulse source k, gated by mask bit k+1. A write with `msk_we_i` loads `msk_wdata_i` at the next edge.
- R5: `vec_o` is the lowest-numbered enabled pending vector, and 0 when nothing is pending. Lower numbers win.
- R6: The level source has no flag. It requests service only in cycles where `lvl_i` is high, and dropping `lvl_i` before the take withdraws it.
- R7: A take (`irq_o` and `take_i` both high) clears the global enable at the next edge. If the taken vector is k+1, it also clears `flags_o[k]`.
- R8: `gie_set_i` or `reti_i` sets the global enable at the next edge, and `gie_clr_i` clears it. A take in the same cycle overrides both.
- R9: If a set and a clear (hardware or software) hit the same flag in the same cycle, the flag ends up set.
- R10: A flag that was raised while masked or while the global enable was off is requested as soon as both are on.
- R11: `take_i` while `irq_o` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Pulse-type event per source |
| lvl_i | input | 1 | Level-type external request |
| msk_we_i | input | 1 | Load the enable mask |
| msk_wdata_i | input | N_SRC+1 | New mask (bit 0 = level source) |
| flg_wr_i | input | 1 | Software flag clear strobe |
| flg_wdata_i | input | N_SRC | Write-one-to-clear pattern |
| flags_o | output | N_SRC | Current flags |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_i | input | 1 | Vector taken (ready) |
| irq_o | output | 1 | Interrupt request (valid) |
| vec_o | output | VEC_W | Vector index of the selected source |

## Verification
The bench drives several stimulus patterns. Single events with the mask off show that flags are latched independently of enabling. Simultaneous events on several sources, serviced one take at a time, separate priority order from arrival order. Same-cycle collisions of an event with a take or with a software clear check that the set wins. A level request raised and dropped without a take shows that it leaves no trace. A long pseudo-random run then mixes all strobes, and a behavioural model checks every cycle for mis-ordered global-enable updates.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {GIE_HOLD, GIE_ON, GIE_OFF} gie_op_e;

  function automatic int unsigned vec_width(int unsigned n_src);
    return (n_src + 1 <= 2) ? 1 : $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] hw_clr_i,
  output logic [N_SRC-1:0] flags_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flags_o[k] <= 1'b0;
      else if (set_i[k])                   flags_o[k] <= 1'b1;
      else if (sw_clr_i[k] || hw_clr_i[k]) flags_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned IDX_W = 4
) (
  input  logic [WIDTH-1:0] pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl
  import irq_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic reti_i,
  output logic gie_o
);
  gie_op_e op;

  always_comb begin
    if (take_i)               op = GIE_OFF;
    else if (set_i || reti_i) op = GIE_ON;
    else if (clr_i)           op = GIE_OFF;
    else                      op = GIE_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_o <= 1'b0;
    else begin
      case (op)
        GIE_ON:  gie_o <= 1'b1;
        GIE_OFF: gie_o <= 1'b0;
        default: gie_o <= gie_o;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned N_VEC = N_SRC + 1,
  localparam int unsigned VEC_W = vec_width(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             lvl_i,
  input  logic             msk_we_i,
  input  logic [N_VEC-1:0] msk_wdata_i,
  input  logic             flg_wr_i,
  input  logic [N_SRC-1:0] flg_wdata_i,
  output logic [N_SRC-1:0] flags_o,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             reti_i,
  input  logic             take_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_VEC-1:0] mask_q;
  logic [N_VEC-1:0] pend;
  logic [N_SRC-1:0] sw_clr;
  logic [N_SRC-1:0] hw_clr;
  logic             any_pend;
  logic             gie_q;
  logic             taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (msk_we_i) mask_q <= msk_wdata_i;
  end

  assign pend   = {flags_o, lvl_i} & mask_q;
  assign taken  = irq_o && take_i;
  assign sw_clr = flg_wr_i ? flg_wdata_i : '0;

  for (genvar k = 0; k < N_SRC; k++) begin : g_hclr
    assign hw_clr[k] = taken && (vec_o == VEC_W'(k + 1));
  end

  irq_flag_bank #(.N_SRC(N_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_i),
    .sw_clr_i (sw_clr),
    .hw_clr_i (hw_clr),
    .flags_o  (flags_o)
  );

  irq_prio_enc #(.WIDTH(N_VEC), .IDX_W(VEC_W)) u_enc (
    .pend_i (pend),
    .any_o  (any_pend),
    .idx_o  (vec_o)
  );

  irq_gie_ctl u_gie (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (taken),
    .set_i  (gie_set_i),
    .clr_i  (gie_clr_i),
    .reti_i (reti_i),
    .gie_o  (gie_q)
  );

  assign irq_o = gie_q && any_pend;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] flags_o,
  input logic             gie_set_i,
  input logic             reti_i,
  input logic             take_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             gie_q
);
  logic [N_SRC-1:0] hot_c;

  always_comb begin
    hot_c = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (vec_o == VEC_W'(k + 1)) hot_c[k] = 1'b1;
    end
  end

  // R7: a take leaves no request in the following cycle
  a_r7_take_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && take_i) |=> !irq_o);

  // R7: the flag of the taken pulse source is gone next cycle
  a_r7_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && take_i && |(hot_c & ~evt_i)) |=> !(|(flags_o & $past(hot_c & ~evt_i))));

  // R9: an event always leaves its flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  // R8: return or set restores the global enable when no take collides
  a_r8_gie_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ((reti_i || gie_set_i) && !(irq_o && take_i)) |=> gie_q);

  // R4: a request implies the global enable is on
  a_r4_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_q);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .flags_o   (flags_o),
  .gie_set_i (gie_set_i),
  .reti_i    (reti_i),
  .take_i    (take_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .gie_q     (gie_q)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
  localparam int N = 8;
  localparam int VW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  evt = '0;
  logic          lvl = 0;
  logic          msk_we = 0;
  logic [N:0]    msk_wd = '0;
  logic          flg_wr = 0;
  logic [N-1:0]  flg_wd = '0;
  logic [N-1:0]  flags;
  logic          gset = 0, gclr = 0, reti = 0, take = 0;
  logic          irq;
  logic [VW-1:0] vec;

  irq_flag_ctrl #(.N_SRC(N)) i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .lvl_i(lvl),
    .msk_we_i(msk_we), .msk_wdata_i(msk_wd),
    .flg_wr_i(flg_wr), .flg_wdata_i(flg_wd), .flags_o(flags),
    .gie_set_i(gset), .gie_clr_i(gclr), .reti_i(reti),
    .take_i(take), .irq_o(irq), .vec_o(vec)
  );

  always #10 clk = ~clk;

  int    n_vec = 0, n_bad = 0, cycles = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_flag [N];
  bit m_mask [N+1];
  bit m_gie;

  function automatic int m_vec();
    if (m_mask[0] && lvl) return 0;
    for (int s = 0; s < N; s++) if (m_mask[s+1] && m_flag[s]) return s + 1;
    return 0;
  endfunction

  function automatic bit m_any();
    if (m_mask[0] && lvl) return 1;
    for (int s = 0; s < N; s++) if (m_mask[s+1] && m_flag[s]) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[s]) m_flag[s] = 0;
      foreach (m_mask[s]) m_mask[s] = 0;
      m_gie = 0;
    end else begin
      bit tk;
      int tv;
      tk = m_gie && m_any() && take;
      tv = m_vec();
      for (int s = 0; s < N; s++) begin
        if (evt[s]) m_flag[s] = 1;
        else if ((flg_wr && flg_wd[s]) || (tk && tv == s + 1)) m_flag[s] = 0;
      end
      if (tk) m_gie = 0;
      else if (gset || reti) m_gie = 1;
      else if (gclr) m_gie = 0;
      if (msk_we) for (int s = 0; s <= N; s++) m_mask[s] = msk_wd[s];
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int ef;
    ef = 0;
    for (int s = 0; s < N; s++) ef |= (int'(m_flag[s]) << s);
    cmp("flags_o", int'(flags), ef);
    cmp("irq_o", int'(irq), int'(m_gie && m_any()));
    cmp("vec_o", int'(vec), m_vec());
  endtask

  // one clock: apply current inputs, compare after the edge, clear strobes
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    evt = '0; msk_we = 0; flg_wr = 0; flg_wd = '0;
    gset = 0; gclr = 0; reti = 0; take = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("reset irq_o", int'(irq), 0);
    cmp("reset flags_o", int'(flags), 0);
    rst_n = 1;
    cyc();

    tag = "R2"; evt = 8'h08; cyc();           // flag 3 while masked
    cmp("flag3 latched", int'(flags[3]), 1);
    cyc();

    tag = "R10"; msk_we = 1; msk_wd = 9'h010; cyc();
    gset = 1; cyc();                          // request for vector 4
    cmp("held flag requested", int'(vec), 4);

    tag = "R5"; evt = 8'h22; msk_we = 1; msk_wd = 9'h1FE; cyc();
    cmp("lowest vector wins", int'(vec), 2);

    tag = "R7"; take = 1; cyc();
    cmp("taken flag cleared", int'(flags[1]), 0);
    cmp("gie off after take", int'(irq), 0);

    tag = "R11"; take = 1; cyc();             // no request present
    cmp("ignored take keeps flag3", int'(flags[3]), 1);

    tag = "R8"; reti = 1; cyc();
    cmp("reti restores request", int'(vec), 4);

    tag = "R6"; msk_we = 1; msk_wd = 9'h1FF; lvl = 1; cyc();
    cmp("level wins vector 0", int'(vec), 0);
    lvl = 0; cyc();
    cmp("level withdrawn", int'(vec), 4);

    tag = "R9"; evt = 8'h08; take = 1; cyc(); // set vs hardware clear
    cmp("set beats take clear", int'(flags[3]), 1);
    reti = 1; cyc();
    evt = 8'h20; flg_wr = 1; flg_wd = 8'h20; cyc();
    cmp("set beats sw clear", int'(flags[5]), 1);

    tag = "R3"; flg_wr = 1; flg_wd = 8'h08; cyc();
    cmp("sw clear only bit3", int'(flags), 8'h20);

    tag = "R8"; gclr = 1; cyc();
    cmp("gie_clr drops request", int'(irq), 0);
    gset = 1; cyc();
    take = 1; gset = 1; cyc();
    cmp("take beats set", int'(irq), 0);

    tag = "R4";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      evt    = ((r & 7) == 0) ? N'($urandom) : '0;
      lvl    = (r >> 3) % 5 == 0;
      msk_we = (r >> 6) % 9 == 0; msk_wd = (N+1)'($urandom);
      flg_wr = (r >> 10) % 7 == 0; flg_wd = N'($urandom);
      gset   = (r >> 13) % 6 == 0;
      gclr   = (r >> 16) % 11 == 0;
      reti   = (r >> 19) % 5 == 0;
      take   = (r >> 22) % 2 == 0;
      cyc();
    end

    done = 1;
    report();
    $finish;
  end
endmodule